// File: doc/BRIEF.md
# Predicated Writeback Controller

This block sits beside the execute, memory and writeback stages of a five-stage in-order pipeline. It decides, while an instruction is in execute, whether that instruction may have any architectural effect. It then carries that decision with the instruction through the memory and writeback stages. Conditional moves and conditional loads test their condition operand for zero or nonzero. Predicated ALU operations read a one-bit predicate register. Compare operations write a predicate register in writeback.

A canceled instruction still occupies its memory and writeback slots. In those slots it issues no memory read, writes no register and raises no exception. The block also holds the predicate register file. It forwards a compare result that is sitting in writeback. When a predicated operation in execute needs a predicate whose compare is still in the memory stage, it raises a one-cycle stall.

Kind encoding on `ex_kind`:

| Code | Kind |
|------|------|
| 0 | plain register-writing operation |
| 1 | conditional move |
| 2 | conditional load |
| 3 | compare writing a predicate |
| 4 | predicated ALU operation |
| 5 to 7 | unused |

Top module: `predwb_ctrl`

## Requirements
- R1: During synchronous active-low reset, and at the first cycle after it, `ex_stall`, `mem_rd_req`, `wb_slot`, `wb_we` and `wb_exc` are 0. Every predicate register except register 0 resets to false.
- R2: A conditional move (kind 1) with `ex_test_nz`=0 writes its destination only if `ex_cond` is zero. With `ex_test_nz`=1 it writes only if `ex_cond` is nonzero. Otherwise `wb_we` stays 0.
- R3: A conditional load (kind 2) whose condition, tested as in R2, holds raises `mem_rd_req` with `mem_rd_addr` equal to its execute-stage `ex_addr` one cycle after execute. It then raises `wb_we` two cycles after execute. A load whose condition fails raises neither.
- R4: `wb_exc` rises two cycles after execute only for an instruction that signalled `ex_fault` and whose condition or predicate is true. A canceled instruction never raises it.
- R5: Every instruction accepted in execute (`ex_valid`=1, `ex_stall`=0) shows `wb_slot`=1 two cycles later, whether or not it was canceled.
- R6: A compare (kind 3) writes `ex_cmp_res` into predicate `ex_pidx` at the end of its writeback cycle. A predicated ALU operation (kind 4) writes its destination only if predicate `ex_pidx` is true. A compare that is in writeback at that moment is seen through forwarding.
- R7: Predicate register 0 always reads true. A compare targeting it has no effect, so a kind-4 operation on predicate 0 always writes.
- R8: When a kind-4 operation in execute reads a nonzero predicate index that a compare in the memory stage will write, `ex_stall` is 1 for exactly one cycle. The memory stage receives an empty slot for that cycle.
- R9: A plain operation (kind 0) always writes its destination. A compare never writes a general register.
- R10: Codes 5 to 7 on `ex_kind` occupy a slot but write nothing, read nothing and raise no exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| ex_valid | input | 1 | instruction present in execute |
| ex_kind | input | 3 | instruction kind code |
| ex_test_nz | input | 1 | 0: condition holds when operand is zero; 1: when nonzero |
| ex_cond | input | DW | condition operand value |
| ex_pidx | input | PW | predicate index read (kind 4) or written (kind 3) |
| ex_cmp_res | input | 1 | compare outcome for kind 3 |
| ex_rd | input | RW | destination register number |
| ex_addr | input | AW | execute-stage effective address |
| ex_fault | input | 1 | instruction would raise an exception |
| ex_stall | output | 1 | hold execute inputs for one cycle |
| mem_rd_req | output | 1 | memory read request in the memory stage |
| mem_rd_addr | output | AW | address of the memory read |
| wb_slot | output | 1 | an instruction, live or canceled, is in writeback |
| wb_we | output | 1 | register write enable in writeback |
| wb_rd | output | RW | register written in writeback |
| wb_exc | output | 1 | exception taken in writeback |

## Verification
The bench aims at a compare followed directly by a predicated operation on the same predicate. A design without the stall would act on a stale predicate. A design that stalled but did not forward from writeback would read the old value a second time. It targets predicate 0 after a compare has tried to clear it; a design that stored that write would cancel a write that must happen. It also sends faulting instructions through with false conditions. A design that let exceptions escape canceled slots would raise `wb_exc`. A design that dropped canceled slots would lose `wb_slot`. Random mixes on a small set of predicate indices keep these hazards frequent, and unused kind codes are mixed in as well.

// File: rtl/predwb_pkg.sv
// Package: kind codes and decode helpers shared by the predicated
// writeback controller. Assumes a 3-bit kind field from decode.
package predwb_pkg;

    typedef enum logic [2:0] {
        K_PLAIN = 3'd0,
        K_CMOV  = 3'd1,
        K_CLOAD = 3'd2,
        K_CMP   = 3'd3,
        K_PALU  = 3'd4
    } kind_e;

    // True for kinds that write a general register when live.
    function automatic logic writes_reg(input logic [2:0] k);
        return (k == K_PLAIN) || (k == K_CMOV) || (k == K_CLOAD) || (k == K_PALU);
    endfunction

endpackage

// File: rtl/predwb_pred_file.sv
// Predicate register file: NPRED one-bit registers, written by compares in
// writeback. Index 0 is hard-wired true. A write in flight is forwarded to
// the read port in the same cycle. Assumes NPRED is a power of two.
module predwb_pred_file #(
    parameter int NPRED = 64,
    parameter int PW    = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic          wr_val,
    input  logic [PW-1:0] rd_idx,
    output logic          rd_val
);

    logic [NPRED-1:0] pred_q;

    // Storage update: compares commit here; index 0 is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            pred_q[wr_idx] <= wr_val;
        end
    end

    // Read port: constant true for index 0, then forwarding, then storage.
    always_comb begin
        if (rd_idx == '0) begin
            rd_val = 1'b1;
        end else if (wr_en && (wr_idx == rd_idx)) begin
            rd_val = wr_val;
        end else begin
            rd_val = pred_q[rd_idx];
        end
    end

    AST_P0_READS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |-> rd_val); // R7

    AST_P0_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (pred_q[0] == 1'b0)); // R7

endmodule

// File: rtl/predwb_qualify.sv
// Execute-stage qualifier: evaluates the zero/nonzero test or the predicate
// for the instruction in execute, and detects a predicate still pending in
// the memory stage. Purely combinational; assumes the predicate read value
// already includes forwarding from writeback.
module predwb_qualify #(
    parameter int DW = 32,
    parameter int PW = 6
) (
    input  logic          ex_valid,
    input  logic [2:0]    ex_kind,
    input  logic          ex_test_nz,
    input  logic [DW-1:0] ex_cond,
    input  logic [PW-1:0] ex_pidx,
    input  logic          pred_val,
    input  logic          mem_cmp_pend,
    input  logic [PW-1:0] mem_cmp_idx,
    output logic          go,
    output logic          stall,
    output logic          adv
);
    import predwb_pkg::*;

    logic cond_zero;

    // Qualification: decide whether the instruction may take effect.
    always_comb begin
        cond_zero = (ex_cond == '0);
        case (ex_kind)
            K_PLAIN, K_CMP:  go = 1'b1;
            K_CMOV, K_CLOAD: go = ex_test_nz ? !cond_zero : cond_zero;
            K_PALU:          go = pred_val;
            default:         go = 1'b0;
        endcase
    end

    // Hazard: a predicated op must wait while its compare is in memory.
    always_comb begin
        stall = ex_valid && (ex_kind == K_PALU) && (ex_pidx != '0)
                && mem_cmp_pend && (mem_cmp_idx == ex_pidx);
        adv   = ex_valid && !stall;
    end

endmodule

// File: rtl/predwb_stage_pipe.sv
// Memory and writeback stage registers. Each slot carries its qualification
// bit, which gates the memory read, the register write and the exception.
// Canceled slots keep flowing. Assumes adv is 0 whenever execute is empty
// or stalled.
module predwb_stage_pipe #(
    parameter int AW = 32,
    parameter int RW = 5,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          go,
    input  logic [2:0]    ex_kind,
    input  logic [RW-1:0] ex_rd,
    input  logic [AW-1:0] ex_addr,
    input  logic          ex_fault,
    input  logic [PW-1:0] ex_pidx,
    input  logic          ex_cmp_res,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    output logic          mem_cmp_pend,
    output logic [PW-1:0] mem_cmp_idx,
    output logic          wb_slot,
    output logic          wb_we,
    output logic [RW-1:0] wb_rd,
    output logic          wb_exc,
    output logic          pf_wr_en,
    output logic [PW-1:0] pf_wr_idx,
    output logic          pf_wr_val
);
    import predwb_pkg::*;

    logic          m_v, m_go, m_fault, m_res;
    logic [2:0]    m_kind;
    logic [RW-1:0] m_rd;
    logic [AW-1:0] m_addr;
    logic [PW-1:0] m_pidx;
    logic          w_v, w_go, w_fault, w_res;
    logic [2:0]    w_kind;
    logic [RW-1:0] w_rd;
    logic [PW-1:0] w_pidx;

    // Memory-stage register: takes the execute slot or a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_v <= 1'b0; m_go <= 1'b0; m_fault <= 1'b0; m_res <= 1'b0;
            m_kind <= K_PLAIN; m_rd <= '0; m_addr <= '0; m_pidx <= '0;
        end else begin
            m_v <= adv; m_go <= go; m_fault <= ex_fault; m_res <= ex_cmp_res;
            m_kind <= ex_kind; m_rd <= ex_rd; m_addr <= ex_addr; m_pidx <= ex_pidx;
        end
    end

    // Writeback-stage register: follows the memory stage every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_v <= 1'b0; w_go <= 1'b0; w_fault <= 1'b0; w_res <= 1'b0;
            w_kind <= K_PLAIN; w_rd <= '0; w_pidx <= '0;
        end else begin
            w_v <= m_v; w_go <= m_go; w_fault <= m_fault; w_res <= m_res;
            w_kind <= m_kind; w_rd <= m_rd; w_pidx <= m_pidx;
        end
    end

    // Memory-stage outputs: read only for a live conditional load.
    always_comb begin
        mem_rd_req   = m_v && m_go && (m_kind == K_CLOAD);
        mem_rd_addr  = m_addr;
        mem_cmp_pend = m_v && (m_kind == K_CMP);
        mem_cmp_idx  = m_pidx;
    end

    // Writeback outputs: writes and exceptions only for live slots.
    always_comb begin
        wb_slot   = w_v;
        wb_we     = w_v && w_go && writes_reg(w_kind);
        wb_rd     = w_rd;
        wb_exc    = w_v && w_go && w_fault;
        pf_wr_en  = w_v && (w_kind == K_CMP);
        pf_wr_idx = w_pidx;
        pf_wr_val = w_res;
    end

    AST_LOAD_FROM_LIVE_EX: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> $past(adv && go && (ex_kind == K_CLOAD))); // R3

    AST_EXC_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_exc |-> $past(m_v && m_go && m_fault)); // R4

    AST_SLOT_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        m_v |=> wb_slot); // R5

endmodule

// File: rtl/predwb_ctrl.sv
// Top of the predicated writeback controller. Qualifies the instruction in
// execute, stalls one cycle on a predicate pending in memory, and gates the
// memory read, register write and exception of each slot. Assumes upstream
// holds the execute inputs while ex_stall is 1.
module predwb_ctrl #(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int RW    = 5,
    parameter int NPRED = 64,
    localparam int PW   = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_valid,
    input  logic [2:0]    ex_kind,
    input  logic          ex_test_nz,
    input  logic [DW-1:0] ex_cond,
    input  logic [PW-1:0] ex_pidx,
    input  logic          ex_cmp_res,
    input  logic [RW-1:0] ex_rd,
    input  logic [AW-1:0] ex_addr,
    input  logic          ex_fault,
    output logic          ex_stall,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    output logic          wb_slot,
    output logic          wb_we,
    output logic [RW-1:0] wb_rd,
    output logic          wb_exc
);

    logic          pred_val, go, adv;
    logic          mem_cmp_pend;
    logic [PW-1:0] mem_cmp_idx;
    logic          pf_wr_en, pf_wr_val;
    logic [PW-1:0] pf_wr_idx;

    predwb_pred_file #(.NPRED(NPRED), .PW(PW)) u_pred_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pf_wr_en), .wr_idx(pf_wr_idx), .wr_val(pf_wr_val),
        .rd_idx(ex_pidx), .rd_val(pred_val)
    );

    predwb_qualify #(.DW(DW), .PW(PW)) u_qualify (
        .ex_valid(ex_valid), .ex_kind(ex_kind), .ex_test_nz(ex_test_nz),
        .ex_cond(ex_cond), .ex_pidx(ex_pidx), .pred_val(pred_val),
        .mem_cmp_pend(mem_cmp_pend), .mem_cmp_idx(mem_cmp_idx),
        .go(go), .stall(ex_stall), .adv(adv)
    );

    predwb_stage_pipe #(.AW(AW), .RW(RW), .PW(PW)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(adv), .go(go),
        .ex_kind(ex_kind), .ex_rd(ex_rd), .ex_addr(ex_addr),
        .ex_fault(ex_fault), .ex_pidx(ex_pidx), .ex_cmp_res(ex_cmp_res),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_cmp_pend(mem_cmp_pend), .mem_cmp_idx(mem_cmp_idx),
        .wb_slot(wb_slot), .wb_we(wb_we), .wb_rd(wb_rd), .wb_exc(wb_exc),
        .pf_wr_en(pf_wr_en), .pf_wr_idx(pf_wr_idx), .pf_wr_val(pf_wr_val)
    );

    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_stall |=> !ex_stall); // R8

    AST_ACCEPT_REACHES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_stall) |=> ##1 wb_slot); // R5

    AST_STALL_NEEDS_PRED_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ex_stall |-> (ex_valid && (ex_kind == 3'd4))); // R8

endmodule

// File: tb/test_predwb_ctrl.sv
`timescale 1ns/100ps
module test_predwb_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0, ex_test_nz = 1'b0, ex_cmp_res = 1'b0, ex_fault = 1'b0;
    logic [2:0]  ex_kind = 3'd0;
    logic [31:0] ex_cond = '0, ex_addr = '0;
    logic [5:0]  ex_pidx = '0;
    logic [4:0]  ex_rd = '0;
    logic        ex_stall, mem_rd_req, wb_slot, wb_we, wb_exc;
    logic [31:0] mem_rd_addr;
    logic [4:0]  wb_rd;

    int n_chk = 0, n_fail = 0;
    logic last_stall = 1'b0;

    // Bench model state built from the requirements.
    logic        pf_m [64];
    logic        m_v, m_go, m_fault, m_res, w_v, w_go, w_fault, w_res;
    logic [2:0]  m_kind, w_kind;
    logic [4:0]  m_rd, w_rd;
    logic [5:0]  m_pidx, w_pidx;
    logic [31:0] m_addr;

    always #2.5 clk = ~clk;

    predwb_ctrl i_predwb_ctrl (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_kind(ex_kind),
        .ex_test_nz(ex_test_nz), .ex_cond(ex_cond), .ex_pidx(ex_pidx),
        .ex_cmp_res(ex_cmp_res), .ex_rd(ex_rd), .ex_addr(ex_addr),
        .ex_fault(ex_fault), .ex_stall(ex_stall), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .wb_slot(wb_slot), .wb_we(wb_we),
        .wb_rd(wb_rd), .wb_exc(wb_exc)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic pred_read(input logic [5:0] idx);
        if (idx == 0) return 1'b1;
        if (w_v && w_kind == 3'd3 && w_pidx == idx) return w_res;
        return pf_m[idx];
    endfunction

    function automatic logic model_go(input logic [2:0] k, input logic nz,
                                      input logic [31:0] c, input logic p);
        case (k)
            3'd0, 3'd3: return 1'b1;
            3'd1, 3'd2: return nz ? (c != 0) : (c == 0);
            3'd4:       return p;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic string we_tag(input logic [2:0] k, input logic [5:0] p);
        case (k)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd4: return (p == 0) ? "R7" : "R6";
            3'd0, 3'd3: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        foreach (pf_m[i]) pf_m[i] = 1'b0;
        m_v = 0; m_go = 0; m_fault = 0; m_res = 0; m_kind = 0; m_rd = 0; m_pidx = 0; m_addr = 0;
        w_v = 0; w_go = 0; w_fault = 0; w_res = 0; w_kind = 0; w_rd = 0; w_pidx = 0;
    endtask

    task automatic drive(input logic v, input logic [2:0] k, input logic nz,
                         input logic [31:0] c, input logic [5:0] p, input logic r,
                         input logic [4:0] d, input logic [31:0] a, input logic f);
        ex_valid = v; ex_kind = k; ex_test_nz = nz; ex_cond = c; ex_pidx = p;
        ex_cmp_res = r; ex_rd = d; ex_addr = a; ex_fault = f;
    endtask

    // One clock: called just after a falling edge with inputs driven.
    task automatic tick();
        logic es, eg, we_exp;
        #1;
        es = ex_valid && ex_kind == 3'd4 && ex_pidx != 0 && m_v && m_kind == 3'd3 && m_pidx == ex_pidx;
        eg = model_go(ex_kind, ex_test_nz, ex_cond, pred_read(ex_pidx));
        chk(ex_stall, es, "R8", "ex_stall");
        @(posedge clk); #1;
        if (w_v && w_kind == 3'd3 && w_pidx != 0) pf_m[w_pidx] = w_res;
        w_v = m_v; w_go = m_go; w_fault = m_fault; w_res = m_res;
        w_kind = m_kind; w_rd = m_rd; w_pidx = m_pidx;
        m_v = ex_valid && !es; m_go = eg; m_fault = ex_fault; m_res = ex_cmp_res;
        m_kind = ex_kind; m_rd = ex_rd; m_pidx = ex_pidx; m_addr = ex_addr;
        chk(mem_rd_req, m_v && m_go && m_kind == 3'd2, "R3", "mem_rd_req");
        if (m_v && m_go && m_kind == 3'd2) chk(mem_rd_addr, m_addr, "R3", "mem_rd_addr");
        chk(wb_slot, w_v, "R5", "wb_slot");
        we_exp = w_v && w_go && (w_kind == 3'd0 || w_kind == 3'd1 || w_kind == 3'd2 || w_kind == 3'd4);
        chk(wb_we, we_exp, we_tag(w_kind, w_pidx), "wb_we");
        if (we_exp) chk(wb_rd, w_rd, we_tag(w_kind, w_pidx), "wb_rd");
        chk(wb_exc, w_v && w_go && w_fault, "R4", "wb_exc");
        last_stall = es;
        @(negedge clk);
    endtask

    task automatic rand_inputs();
        int sel = $urandom_range(0, 9);
        logic [2:0] k;
        logic [31:0] c;
        c = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom;
        case (sel)
            0, 1: k = 3'd0;
            2:    k = 3'd1;
            3:    k = 3'd2;
            4, 5: k = 3'd3;
            6, 7: k = 3'd4;
            default: k = 3'($urandom_range(5, 7));
        endcase
        drive(sel != 9, k, 1'($urandom), c, 6'($urandom_range(0, 3)), 1'($urandom),
              5'($urandom), $urandom, ($urandom_range(0, 3) == 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        drive(1, 3'd2, 0, 0, 0, 0, 5'd3, 32'h40, 1);
        repeat (3) @(posedge clk);
        #1;
        chk(mem_rd_req, 0, "R1", "mem_rd_req in reset");
        chk(wb_slot, 0, "R1", "wb_slot in reset");
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk(ex_stall, 0, "R1", "ex_stall after reset");
        chk(wb_we, 0, "R1", "wb_we after reset");
        chk(wb_exc, 0, "R1", "wb_exc after reset");
        @(negedge clk);

        // R8 and R6: compare clears p5, predicated op on p5 follows at once.
        drive(1, 3'd3, 0, 0, 6'd5, 1'b0, 0, 0, 0); tick();
        drive(1, 3'd4, 0, 0, 6'd5, 0, 5'd9, 0, 1); tick();
        if (!last_stall) begin n_chk++; n_fail++; $display("FAIL R8 stall: actual 0 expected 1"); end
        else n_chk++;
        tick();
        repeat (3) begin drive(0, 0, 0, 0, 0, 0, 0, 0, 0); tick(); end

        // R7: compare aims to clear p0; predicated op on p0 still writes.
        drive(1, 3'd3, 0, 0, 6'd0, 1'b0, 0, 0, 0); tick();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); tick(); tick();
        drive(1, 3'd4, 0, 0, 6'd0, 0, 5'd17, 0, 0); tick();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); tick(); tick();

        // R2, R3, R4: conditional forms with both test senses, faults on annulled.
        drive(1, 3'd1, 0, 32'd0, 0, 0, 5'd4, 0, 0); tick();
        drive(1, 3'd1, 0, 32'd7, 0, 0, 5'd5, 0, 1); tick();
        drive(1, 3'd2, 1, 32'd7, 0, 0, 5'd6, 32'h1234, 0); tick();
        drive(1, 3'd2, 1, 32'd0, 0, 0, 5'd7, 32'h5678, 1); tick();
        // R10: unused kind code with fault set.
        drive(1, 3'd6, 0, 0, 0, 0, 5'd8, 32'h9, 1); tick();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); tick(); tick();

        for (int i = 0; i < 4000; i++) begin
            if (!last_stall) rand_inputs();
            tick();
        end
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0); tick(); tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule